// File: doc/BRIEF.md
# Nearest Power-of-Two Radix Selector

This block takes a non-zero unsigned operand and returns the power of two closest to it, along with that power's exponent. Arithmetic units that rewrite a product as a base plus a small residue use it to pick the base. The unit first finds the highest set bit of the operand, at position k. That gives the two powers of two that bracket the operand: 2^k below it and 2^(k+1) above it. The operand is then compared with the midpoint of those two powers, which is 3·2^(k-1), and the nearer power is chosen.

The block is purely combinational. Its outputs follow the operand within the same cycle, and it holds no state. The radix output is one bit wider than the operand, because operands near the top of the range round up to 2^W. An operand of zero has no nearest power of two. For zero the block raises a flag and forces both numeric outputs to zero.

Top module: `nearest_radix_sel`

## Requirements
- R1: For an operand that is an exact power of two, 2^k, the radix output is 2^k and the exponent output is k.
- R2: For a non-zero operand whose highest set bit is at position k and whose value is strictly greater than 3·2^(k-1), the radix is 2^(k+1) and the exponent is k+1.
- R3: For a non-zero operand whose value is strictly less than 3·2^(k-1), where k is the position of its highest set bit, the radix is 2^k and the exponent is k.
- R4: When the operand equals the midpoint 3·2^(k-1) exactly (k ≥ 1, for example 3, 6 or 0xC000), the lower base 2^k is selected and the exponent is k.
- R5: The operand value 1 yields radix 1 and exponent 0. The midpoint for k = 0 is taken as 1.5.
- R6: A zero operand drives `zero_o` to 1 and drives both `radix_o` and `exp_o` to 0. Any non-zero operand drives `zero_o` to 0.
- R7: For a non-zero operand, `radix_o` equals 1 shifted left by `exp_o`. The 17-bit radix reaches 0x10000 with exponent 16 for operands above 0xC000, such as 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 16 | Unsigned operand to be rounded to a power of two |
| radix_o | output | 17 | Selected power of two (zero when the operand is zero) |
| exp_o | output | 5 | Exponent of the selected radix |
| zero_o | output | 1 | High when the operand is zero and the outputs are not meaningful |

## Verification
The hardest case to reach is an exact tie. The operand must equal 3·2^(k-1) for one of only fifteen values of k, and uniform random operands almost never land there. The stimulus therefore builds tie values, exact powers of two, and their immediate neighbours (one below and one above) directly from a random k, and mixes them with plain uniform operands. The operands 0, 1, 3 and 0xFFFF are also applied directly. These cover the zero flag, the k = 0 midpoint and the largest radix.

// File: rtl/nearest_radix_pkg.sv
package nearest_radix_pkg;

  // Distance between two unsigned values, used by the nearness checks.
  function automatic logic [31:0] abs_diff(input logic [31:0] a, input logic [31:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

  // Twice the midpoint of 2^k and 2^(k+1), i.e. 3*2^k, in the given width.
  function automatic logic [31:0] twice_mid(input logic [31:0] lo, input logic [31:0] hi);
    return lo + hi;
  endfunction

endpackage

// File: rtl/lead_one_finder.sv
module lead_one_finder #(
  parameter int unsigned W  = 16,
  parameter int unsigned EW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [EW-1:0] pos_o,
  output logic          any_o
);

  logic [W-1:0] lead;

  // Each bit is the leading one when it is set and nothing above it is set.
  generate
    for (genvar i = 0; i < W; i++) begin : g_lead
      if (i == W - 1) begin : g_top
        assign lead[i] = vec_i[i];
      end else begin : g_rest
        assign lead[i] = vec_i[i] & ~(|vec_i[W-1:i+1]);
      end
    end
  endgenerate

  // Encode the one-hot leading position into a binary index.
  always_comb begin
    pos_o = '0;
    for (int i = 0; i < W; i++) begin
      if (lead[i]) pos_o = pos_o | EW'(i);
    end
  end

  assign any_o = |vec_i;

  always_comb begin
    // R1
    lead_onehot_chk: assert ($onehot0(lead))
      else $error("leading-one vector not one-hot");
  end

endmodule

// File: rtl/candidate_gen.sv
module candidate_gen #(
  parameter int unsigned W  = 16,
  parameter int unsigned EW = $clog2(W + 1),
  parameter int unsigned RW = W + 1
) (
  input  logic [EW-1:0] k_i,
  output logic [RW-1:0] lo_o,
  output logic [RW-1:0] hi_o,
  output logic [EW-1:0] k_up_o
);

  localparam logic [RW-1:0] ONE = RW'(1);

  assign lo_o   = ONE << k_i;
  assign k_up_o = k_i + EW'(1);
  assign hi_o   = ONE << k_up_o;

  always_comb begin
    // R7
    cand_ratio_chk: assert (hi_o == (lo_o << 1))
      else $error("upper candidate is not twice the lower one");
  end

endmodule

// File: rtl/mean_compare.sv
module mean_compare #(
  parameter int unsigned W  = 16,
  parameter int unsigned RW = W + 1
) (
  input  logic [W-1:0]  op_i,
  input  logic [RW-1:0] lo_i,
  input  logic [RW-1:0] hi_i,
  output logic          pick_up_o
);

  import nearest_radix_pkg::*;

  localparam int unsigned MW = RW + 1;

  logic [MW-1:0] mean2;
  logic [MW-1:0] op2;

  // Compare in doubled units so the k = 0 midpoint (1.5) stays an integer.
  assign mean2     = MW'(twice_mid(32'(lo_i), 32'(hi_i)));
  assign op2       = {1'b0, op_i, 1'b0};
  assign pick_up_o = op2 > mean2;

endmodule

// File: rtl/nearest_radix_sel.sv
module nearest_radix_sel #(
  parameter int unsigned W  = 16,
  parameter int unsigned EW = $clog2(W + 1),
  parameter int unsigned RW = W + 1
) (
  input  logic [W-1:0]  operand_i,
  output logic [RW-1:0] radix_o,
  output logic [EW-1:0] exp_o,
  output logic          zero_o
);

  import nearest_radix_pkg::*;

  logic [EW-1:0] k;
  logic [EW-1:0] k_up;
  logic          any_set;
  logic [RW-1:0] cand_lo;
  logic [RW-1:0] cand_hi;
  logic          pick_up;
  logic [RW-1:0] other;

  lead_one_finder #(.W(W), .EW(EW)) u_lead (
    .vec_i (operand_i),
    .pos_o (k),
    .any_o (any_set)
  );

  candidate_gen #(.W(W), .EW(EW), .RW(RW)) u_cand (
    .k_i    (k),
    .lo_o   (cand_lo),
    .hi_o   (cand_hi),
    .k_up_o (k_up)
  );

  mean_compare #(.W(W), .RW(RW)) u_mean (
    .op_i      (operand_i),
    .lo_i      (cand_lo),
    .hi_i      (cand_hi),
    .pick_up_o (pick_up)
  );

  assign zero_o  = ~any_set;
  assign radix_o = zero_o ? '0 : (pick_up ? cand_hi : cand_lo);
  assign exp_o   = zero_o ? '0 : (pick_up ? k_up : k);
  assign other   = pick_up ? cand_lo : cand_hi;

  always_comb begin
    // R6
    if (zero_o) zero_outputs_chk: assert (radix_o == '0 && exp_o == '0)
      else $error("zero operand produced non-zero outputs");
    // R7
    if (!zero_o) radix_pow2_chk: assert (radix_o == (RW'(1) << exp_o))
      else $error("radix does not match exponent");
    // R1
    if (!zero_o) bracket_chk: assert (32'(cand_lo) <= 32'(operand_i) && 32'(operand_i) < 32'(cand_hi))
      else $error("candidates do not bracket operand");
    // R2
    if (!zero_o) nearest_chk: assert (abs_diff(32'(operand_i), 32'(radix_o)) <= abs_diff(32'(operand_i), 32'(other)))
      else $error("selected radix is not the nearer candidate");
    // R4
    if (!zero_o && abs_diff(32'(operand_i), 32'(cand_lo)) == abs_diff(32'(operand_i), 32'(cand_hi)))
      tie_low_chk: assert (radix_o == cand_lo)
        else $error("tie not resolved to lower base");
  end

endmodule

// File: tb/nearest_radix_sel_bench.sv
module nearest_radix_sel_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] operand;
  logic [16:0] radix;
  logic [4:0]  expo;
  logic        zero;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  nearest_radix_sel u_nearest_radix_sel (
    .operand_i (operand),
    .radix_o   (radix),
    .exp_o     (expo),
    .zero_o    (zero)
  );

  // Reference: scan all powers, keep the strictly closer one (ties stay low).
  function automatic void ref_model(input logic [15:0] v, output logic [16:0] r,
                                    output logic [4:0] e, output logic z);
    int best_e;
    longint best_d;
    z = (v == 16'd0);
    r = '0;
    e = '0;
    if (!z) begin
      best_e = 0;
      best_d = longint'(v) - 1;
      for (int p = 1; p <= 16; p++) begin
        longint pw = longint'(1) << p;
        longint d  = (pw > longint'(v)) ? pw - longint'(v) : longint'(v) - pw;
        if (d < best_d) begin
          best_d = d;
          best_e = p;
        end
      end
      e = 5'(best_e);
      r = 17'(longint'(1) << best_e);
    end
  endfunction

  function automatic string tag_of(input logic [15:0] v);
    int top;
    longint twice, mid2;
    if (v == 16'd0) return "R6";
    if (v == 16'd1) return "R5";
    if ((v & (v - 16'd1)) == 16'd0) return "R1";
    top = 0;
    for (int i = 0; i < 16; i++) if (v[i]) top = i;
    twice = longint'(v) * 2;
    mid2  = longint'(3) << top;
    if (twice == mid2) return "R4";
    if (twice > mid2) return (top == 15) ? "R7" : "R2";
    return "R3";
  endfunction

  task automatic apply(input logic [15:0] v);
    logic [16:0] er;
    logic [4:0]  ee;
    logic        ez;
    string       t;
    @(posedge clk);
    operand = v;
    @(negedge clk);
    ref_model(v, er, ee, ez);
    t = tag_of(v);
    vectors++;
    if (radix !== er || expo !== ee || zero !== ez) begin
      misses++;
      $display("FAIL %s op=%h radix=%h exp=%0d zero=%b expected radix=%h exp=%0d zero=%b",
               t, v, radix, expo, zero, er, ee, ez);
    end
  endtask

  initial begin
    operand = 16'd0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // R6 zero operand, also the state right after reset
    apply(16'h0000);
    // R5 k = 0
    apply(16'h0001);
    // R1 exact powers
    apply(16'h0002);
    apply(16'h8000);
    // R4 ties
    apply(16'h0003);
    apply(16'h0006);
    apply(16'hC000);
    // R2 just above midpoint, R3 just below
    apply(16'h0007);
    apply(16'hC001);
    apply(16'h0005);
    apply(16'hBFFF);
    // R7 largest radix
    apply(16'hFFFF);
    apply(16'h0000);
    void'($urandom(32'd20240611));
    for (int n = 0; n < 3000; n++) begin
      int k = int'($urandom_range(15, 0));
      logic [15:0] base = 16'(1) << k;
      logic [15:0] mid  = (k == 0) ? 16'd1 : 16'(3 << (k - 1));
      case ($urandom_range(5, 0))
        0: apply(base);
        1: apply(mid);
        2: apply(mid + 16'd1);
        3: apply(mid - 16'd1);
        4: apply(16'(base | 16'($urandom) & (base - 16'd1)));
        default: apply(16'($urandom));
      endcase
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired after %0d vectors, expected completion", vectors);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule